// File: doc/BRIEF.md
# Frame Alignment Offset Meter

This block measures how far an edge on a frame-evaluation input lags the frame synchronization pulse, to half a master-clock period. Software raises a start bit. The meter then waits for the next reference frame edge and counts master-clock cycles from that edge to the first qualifying edge on the evaluation input. At the reference edge after that, the count is published together with a completion flag.

The edge polarity follows a format select. In one format, falling edges of both the frame pulse and the evaluation input are compared. In the other format, rising edges are compared. The evaluation input is also sampled on the falling clock edge, so the result records which half of the clock period the edge fell in. While wide-frame mode is selected, the meter is held inactive.

Top module: `frame_align_meter`

## Requirements
- R1: Synchronous active-low reset clears the whole status word to zero.
- R2: The completion flag (status bit 12) becomes 1 in the cycle after the posedge that detects the second reference frame edge following the accepted start rise. Until then the whole status word reads zero.
- R3: Status reads zero in the cycle after a clock edge that samples the start bit low. While start stays high, a finished result is held unchanged and no new measurement begins.
- R4: A start rise is accepted only if at least one reference frame edge was detected while start was low and wide mode was off, after start last went high. Any other rise starts nothing, and status stays zero.
- R5: Status bits 10..0 give the number of master-clock cycles from the posedge that detects the opening reference edge to the posedge that detects the first qualifying evaluation edge. Later edges are ignored. An evaluation edge detected at the same posedge as the opening reference edge is not counted.
- R6: Status bit 11 is 1 when the captured evaluation edge occurred in the clock-high half (between a posedge and the following negedge). It is 0 when the edge occurred in the clock-low half.
- R7: With the format select at 0, falling edges of the frame pulse and of the evaluation input are used. With it at 1, rising edges are used. Edges of the opposite direction have no effect on the result.
- R8: If no qualifying evaluation edge is detected before the closing reference edge, the flag is still set, bits 10..0 read all ones (2047), and bit 11 reads 0. This includes an evaluation edge detected at the closing edge's own posedge.
- R9: While wide mode is high, status reads zero and any measurement in progress is abandoned. A fresh clear and rise of start is needed afterwards.
- R10: Status bits 15..13 always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | Frame synchronization pulse |
| frame_eval | input | 1 | Frame evaluation input whose edge is measured |
| fmt_rise | input | 1 | Edge select: 0 falling edges, 1 rising edges |
| wide_mode | input | 1 | Wide-frame mode; disables the meter when high |
| meas_start | input | 1 | Software start bit |
| status | output | 16 | {3'b000, done flag, phase bit, 11-bit offset} |

## Verification
Two events can land in the same cycle: the posedge that detects the closing reference edge, and the posedge that detects an evaluation edge. The bench provokes this by driving the evaluation edge in the clock-high half of the closing frame's first cycle. Since an uncounted edge must give phase 0, a saturated count of 2047 with bit 11 clear shows that the closing edge won; a set bit 11 would show a late capture. The same kind of collision at the opening edge is also provoked, and there the evaluation edge must be ignored.

// File: rtl/fam_pkg.sv
// Shared definitions for the frame alignment offset meter.
package fam_pkg;
    // Measurement sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_MEAS  = 2'd2,
        ST_DONE  = 2'd3
    } meas_state_e;

    // Number of always-zero bits at the top of the status word.
    localparam int unsigned RSVD_W = 3;
endpackage

// File: rtl/fam_ref_edge.sv
// Reference edge detector for the frame pulse.
// Flags the posedge at which the pulse is first seen at the level selected by pol,
// after having been at the other level on the previous posedge.
// Assumes frame_sync is synchronous to clk. The history flop loads the live level
// during reset as well, so no false edge is reported when reset is released.
module fam_ref_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    input  logic pol,
    output logic edge_hit
);
    logic last_q;

    // Keeps the level seen on the previous posedge (reset loads the live level).
    always_ff @(posedge clk) begin
        last_q <= sig;
    end

    assign edge_hit = (last_q != pol) && (sig == pol);

    // R7: a detected edge cannot repeat on the next posedge unless the polarity moved.
    p_ref_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> (!edge_hit || (pol != $past(pol))));
endmodule

// File: rtl/fam_phase_edge.sv
// Evaluation edge detector with half-clock resolution.
// The input is sampled on both clock edges. An edge is reported at the posedge where
// the live level first equals pol. phase_hi tells whether the change had already
// shown up at the preceding negedge, i.e. it occurred in the clock-high half.
// Assumes frame_eval changes at most once per clock period.
module fam_phase_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    input  logic pol,
    output logic edge_hit,
    output logic phase_hi
);
    logic pos_q;
    logic neg_q;

    // Posedge history sample (reset loads the live level to avoid a false edge).
    always_ff @(posedge clk) begin
        pos_q <= sig;
    end

    // Mid-period sample taken at the end of the clock-high half.
    always_ff @(negedge clk) begin
        neg_q <= sig;
    end

    assign edge_hit = (pos_q != pol) && (sig == pol);
    assign phase_hi = (neg_q == pol);

    // R7: two consecutive posedges never both report an edge of the same polarity.
    p_eval_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> (!edge_hit || (pol != $past(pol))));
endmodule

// File: rtl/fam_meas_seq.sv
// Measurement sequencer and offset counter.
// Handles priming, arming on a start rise, one full measurement frame, and
// publication of the result at the closing reference edge.
// Assumes one frame spans no more than 2**CNT_W master clocks. Longer windows
// saturate at all ones.
module fam_meas_seq
    import fam_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             wide_mode,
    input  logic             ref_edge,
    input  logic             eval_edge,
    input  logic             eval_hi,
    output logic             done,
    output logic             phase_hi,
    output logic [CNT_W-1:0] offset
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    meas_state_e      state_q;
    logic             start_q;
    logic             primed_q;
    logic             cap_valid_q;
    logic             cap_hi_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cap_cnt_q;
    logic [CNT_W-1:0] next_cnt;

    assign next_cnt = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

    // Tracks the start bit and whether it has been low across a frame edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            start_q <= start;
            if (wide_mode || start) begin
                primed_q <= 1'b0;
            end else if (ref_edge) begin
                primed_q <= 1'b1;
            end
        end
    end

    // Steps through idle, armed, measuring and done; captures and publishes the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            cap_valid_q <= 1'b0;
            cap_hi_q    <= 1'b0;
            cap_cnt_q   <= '0;
            done        <= 1'b0;
            phase_hi    <= 1'b0;
            offset      <= '0;
        end else if (wide_mode || !start) begin
            state_q     <= ST_IDLE;
            cap_valid_q <= 1'b0;
            done        <= 1'b0;
            phase_hi    <= 1'b0;
            offset      <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (!start_q && primed_q) begin
                        state_q <= ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (ref_edge) begin
                        state_q     <= ST_MEAS;
                        cnt_q       <= '0;
                        cap_valid_q <= 1'b0;
                        cap_hi_q    <= 1'b0;
                        cap_cnt_q   <= '0;
                    end
                end
                ST_MEAS: begin
                    if (ref_edge) begin
                        state_q  <= ST_DONE;
                        done     <= 1'b1;
                        offset   <= cap_valid_q ? cap_cnt_q : CNT_MAX;
                        phase_hi <= cap_valid_q ? cap_hi_q : 1'b0;
                    end else begin
                        cnt_q <= next_cnt;
                        if (eval_edge && !cap_valid_q) begin
                            cap_valid_q <= 1'b1;
                            cap_cnt_q   <= next_cnt;
                            cap_hi_q    <= eval_hi;
                        end
                    end
                end
                default: begin
                    state_q <= state_q;
                end
            endcase
        end
    end

    // R3: a low start bit clears the completion flag by the next cycle.
    p_clear_on_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    // R2: the flag only rises when a measurement frame is closed by a reference edge.
    p_done_from_meas_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (($past(state_q) == ST_MEAS) && $past(ref_edge)));

    // R9: wide mode forces the flag low on the next cycle.
    p_wide_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wide_mode |=> !done);

    // R8: the window counter stays at its ceiling instead of wrapping.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEAS && start && !wide_mode && !ref_edge && cnt_q == CNT_MAX)
        |=> (cnt_q == CNT_MAX));

    // R5: once the first edge is captured, later edges leave it untouched.
    p_capture_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEAS && cap_valid_q && start && !wide_mode && !ref_edge)
        |=> ($stable(cap_cnt_q) && $stable(cap_hi_q)));
endmodule

// File: rtl/frame_align_meter.sv
// Frame alignment offset meter, top level.
// Detects reference frame edges and evaluation edges of the polarity chosen by
// fmt_rise, runs the start/complete sequence and packs the status word.
// Assumes all inputs are synchronous to clk.
module frame_align_meter
    import fam_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_sync,
    input  logic                      frame_eval,
    input  logic                      fmt_rise,
    input  logic                      wide_mode,
    input  logic                      meas_start,
    output logic [RSVD_W+CNT_W+1:0]   status
);
    logic             ref_edge;
    logic             eval_edge;
    logic             eval_hi;
    logic             done;
    logic             phase_hi;
    logic [CNT_W-1:0] offset;

    fam_ref_edge u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig      (frame_sync),
        .pol      (fmt_rise),
        .edge_hit (ref_edge)
    );

    fam_phase_edge u_eval (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig      (frame_eval),
        .pol      (fmt_rise),
        .edge_hit (eval_edge),
        .phase_hi (eval_hi)
    );

    fam_meas_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (meas_start),
        .wide_mode (wide_mode),
        .ref_edge  (ref_edge),
        .eval_edge (eval_edge),
        .eval_hi   (eval_hi),
        .done      (done),
        .phase_hi  (phase_hi),
        .offset    (offset)
    );

    assign status = {{RSVD_W{1'b0}}, done, phase_hi, offset};

    // R10: the reserved top bits never read one.
    p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        status[RSVD_W+CNT_W+1:CNT_W+2] == '0);
endmodule

// File: tb/frame_align_meter_tb.sv
module frame_align_meter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 2048;
    localparam int WATCHDOG   = 195000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b1;
    logic        feval = 1'b1;
    logic        fmt = 1'b0;
    logic        wide = 1'b0;
    logic        start = 1'b0;
    logic [15:0] status;

    int n_chk  = 0;
    int n_fail = 0;
    int pos    = 0;

    frame_align_meter u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (fsync),
        .frame_eval (feval),
        .fmt_rise   (fmt),
        .wide_mode  (wide),
        .meas_start (start),
        .status     (status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] mk(input logic d, input logic ph, input int cnt);
        return {3'b000, d, ph, cnt[10:0]};
    endfunction

    task automatic check(input string tag, input logic [15:0] exp);
        n_chk++;
        if (status !== exp) begin
            n_fail++;
            $display("FAIL %s: status actual %h expected %h", tag, status, exp);
        end
    endtask

    // One clock: advance the frame position and drive the frame pulse 2 ns after the edge.
    task automatic step();
        @(posedge clk);
        pos = (pos + 1) % FRAME;
        #2;
        fsync = (pos == 0) ? fmt : ~fmt;
    endtask

    task automatic begin_test(input logic f, input logic eval_init);
        fmt   = f;
        fsync = ~f;
        feval = eval_init;
        start = 1'b0;
        wide  = 1'b0;
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic sync_frame();
        do step(); while (pos != 0);
    endtask

    // Prime (start low over a frame edge), then raise start.
    task automatic arm();
        sync_frame();
        repeat (20) step();
        start = 1'b1;
    endtask

    // One measurement frame. pre: opposite-direction edge, m: qualifying edge,
    // post: extra toggle after capture; -1 disables each. lo selects the clock-low half.
    task automatic measure(input string tag, input int pre, input int m, input bit lo,
                           input int post, input logic [15:0] exp);
        sync_frame();
        for (int k = 0; k < FRAME; k++) begin
            if (k == pre) feval = ~fmt;
            if (k == post) feval = ~fmt;
            if (k == post + 3 && post >= 0) feval = fmt;
            if (k == m) begin
                if (lo) #5;
                feval = fmt;
            end
            step();
        end
        check({tag, " R2 not before closing edge"}, 16'h0000);
        if (m == FRAME) begin
            if (lo) #5;
            feval = fmt;
        end
        step();
        check(tag, exp);
    endtask

    task automatic t_reset();
        begin_test(1'b0, 1'b1);
        check("R1 reset", 16'h0000);
    endtask

    task automatic t_fall_hi();
        begin_test(1'b0, 1'b1);
        arm();
        measure("R5 R6 R10 falling high-half", -1, 37, 1'b0, -1, mk(1, 1, 37));
    endtask

    task automatic t_rise_lo();
        begin_test(1'b1, 1'b0);
        arm();
        measure("R7 R6 rising low-half", -1, 1000, 1'b1, -1, mk(1, 0, 1000));
    endtask

    task automatic t_polarity();
        begin_test(1'b0, 1'b0);
        arm();
        measure("R7 opposite edge ignored", 5, 100, 1'b1, -1, mk(1, 0, 100));
    endtask

    task automatic t_first_only();
        begin_test(1'b1, 1'b0);
        arm();
        measure("R5 first edge only", -1, 50, 1'b0, 60, mk(1, 1, 50));
    endtask

    task automatic t_none();
        begin_test(1'b1, 1'b0);
        arm();
        measure("R8 no edge saturates", -1, -1, 1'b0, -1, mk(1, 0, 2047));
    endtask

    task automatic t_close_tie();
        begin_test(1'b0, 1'b1);
        arm();
        measure("R8 edge at closing edge", -1, FRAME, 1'b0, -1, mk(1, 0, 2047));
    endtask

    task automatic t_open_tie();
        begin_test(1'b0, 1'b1);
        arm();
        measure("R5 edge at opening edge", -1, 0, 1'b0, -1, mk(1, 0, 2047));
    endtask

    task automatic t_last();
        begin_test(1'b1, 1'b0);
        arm();
        measure("R5 last cycle of window", -1, FRAME - 1, 1'b0, -1, mk(1, 1, 2047));
    endtask

    task automatic t_hold_clear();
        begin_test(1'b0, 1'b1);
        arm();
        measure("R5 hold setup", -1, 300, 1'b1, -1, mk(1, 0, 300));
        for (int k = 0; k < 2 * FRAME; k++) begin
            if (k == 100) feval = ~fmt;
            if (k == 300) feval = fmt;
            step();
        end
        check("R3 result held while start high", mk(1, 0, 300));
        start = 1'b0;
        step();
        check("R3 clear on start low", 16'h0000);
        start = 1'b1;
        feval = ~fmt;
        for (int k = 0; k < 2 * FRAME + 10; k++) begin
            if (k == 500) feval = fmt;
            step();
        end
        check("R4 rise without frame edge ignored", 16'h0000);
    endtask

    task automatic t_unprimed();
        begin_test(1'b1, 1'b0);
        start = 1'b1;
        for (int k = 0; k < 3 * FRAME; k++) begin
            if (k == FRAME + 40) feval = fmt;
            step();
        end
        check("R4 unprimed start ignored", 16'h0000);
    endtask

    task automatic t_wide();
        begin_test(1'b0, 1'b1);
        arm();
        sync_frame();
        for (int k = 0; k < FRAME; k++) begin
            if (k == 10) wide = 1'b1;
            if (k == 30) feval = fmt;
            step();
        end
        step();
        check("R9 wide mode aborts", 16'h0000);
        wide = 1'b0;
        for (int k = 0; k < 2 * FRAME; k++) step();
        check("R9 no resume after wide", 16'h0000);
    endtask

    initial begin
        t_reset();
        t_fall_hi();
        t_rise_lo();
        t_polarity();
        t_first_only();
        t_none();
        t_close_tie();
        t_open_tie();
        t_last();
        t_hold_clear();
        t_unprimed();
        t_wide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule